// File: doc/BRIEF.md
# Read-Capture Delay Tap Sweep Calibrator

This block is a hardware sequencer that searches for a working read-capture delay on a memory interface. After a start request it steps a delay tap through every value, from zero up to the largest code. Each value is driven onto all byte-lane tap outputs. At each tap the sequencer launches an external pass/fail test engine with a fixed run count, waits for the engine's completion flag and grades the status word it returns.

Across the sweep the block keeps three results: the number of passing taps, the lowest passing tap and the highest passing tap. When the sweep ends, it drives the midpoint of the lowest and highest passing taps onto every lane. If no tap passed, it drives a fixed fallback tap instead. A one-cycle done pulse then marks the end of calibration. The three results stay on the outputs until the next sweep begins.

Top module: `tap_sweep_cal`

## Requirements
- R1: A start request accepted while idle begins a sweep at tap 0. Each tap is tested exactly once, in ascending order with a step of 1, up to and including tap 63, which gives 64 tests per sweep.
- R2: All four lane tap outputs always carry the same 6-bit value, and that value does not change while the test start output is high.
- R3: The configuration word carries the requested run count of 8 in bits 8:1, with every other bit at zero. For each tap, test start rises once and stays high until status bit 0 (done) is seen. It then falls before the next tap is applied.
- R4: In the status word, bits 8:1 hold the passing-run count and bits 16:9 hold the failing-run count. A tap passes only when the failing count is 0 and the passing count equals 8. A count of 7 or 9 passing runs, or any failing run, makes the tap fail.
- R5: The pass count output equals the number of passing taps in the latest sweep. It is cleared to zero when a sweep starts.
- R6: The first-tap output holds the lowest passing tap and the last-tap output holds the highest passing tap. This holds even when failing taps lie between passing ones.
- R7: When at least one tap passed, the final tap equals (first + last) shifted right by one. The sum is formed 7 bits wide, so that 62 and 63 give 62. The final tap is driven on all four lanes.
- R8: When no tap passed, the final tap is 8, and the pass count, first-tap and last-tap outputs read 0.
- R9: done is high for exactly one cycle, in the first cycle in which the final tap is on the lanes. The lanes and results then hold until the next start.
- R10: A start request that arrives during a sweep is ignored. The sweep continues without restarting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_start_i | input | 1 | Request a calibration sweep |
| cal_done_o | output | 1 | One-cycle pulse when the final tap is applied |
| lane_tap_o | output | 24 | Four 6-bit lane tap values, lane 0 in the low bits |
| bist_go_o | output | 1 | Start of the external test engine |
| bist_cfg_o | output | 9 | Test configuration word, run count in bits 8:1 |
| bist_stat_i | input | 17 | Test status: done bit 0, passes 8:1, fails 16:9 |
| pass_cnt_o | output | 7 | Number of passing taps |
| first_tap_o | output | 6 | Lowest passing tap |
| last_tap_o | output | 6 | Highest passing tap |

## Verification
The bench builds the block with its default parameters: a 6-bit tap, four lanes and 8 runs per test. At this size a full sweep takes only a few hundred cycles, so the bench can run one sweep for every possible single passing tap from 0 to 63. This covers every first/last pair on the diagonal, including both ends of the range. Further sweeps use windows, split regions, the 62/63 overflow pair, an all-fail sweep and near-miss status words (7 passes, 9 passes, 8 passes with 1 fail). These check the pass rule, the 7-bit midpoint and the fallback. A mid-sweep start pulse checks that a running sweep is not restarted.

// File: rtl/tap_cal_pkg.sv
package tap_cal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_WAIT   = 2'd2,
    ST_FINAL  = 2'd3
  } scan_st_t;
endpackage

// File: rtl/tap_status_judge.sv
module tap_status_judge #(
  parameter int CNT_W  = 8,
  parameter int RUNS   = 8,
  localparam int STAT_W = 2 * CNT_W + 1
) (
  input  logic [STAT_W-1:0] stat_i,
  output logic              done_seen_o,
  output logic              tap_ok_o
);
  logic [CNT_W-1:0] good_runs;
  logic [CNT_W-1:0] bad_runs;

  // R4: status layout - done at bit 0, passes above it, fails on top
  always_comb begin
    done_seen_o = stat_i[0];
    good_runs   = stat_i[CNT_W:1];
    bad_runs    = stat_i[2*CNT_W:CNT_W+1];
    tap_ok_o    = (bad_runs == '0) && (good_runs == CNT_W'(RUNS));
  end
endmodule

// File: rtl/tap_window_track.sv
module tap_window_track #(
  parameter int TAP_W   = 6,
  parameter int DEF_TAP = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             hit_i,
  input  logic [TAP_W-1:0] tap_i,
  output logic [TAP_W-1:0] first_o,
  output logic [TAP_W-1:0] last_o,
  output logic [TAP_W:0]   cnt_o,
  output logic [TAP_W-1:0] final_o
);
  localparam logic [TAP_W-1:0] DEF_V = TAP_W'(DEF_TAP);

  logic           fresh_q;
  logic [TAP_W:0] sum;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      first_o <= '0;
      last_o  <= '0;
      cnt_o   <= '0;
      fresh_q <= 1'b1;
    end else if (hit_i) begin
      cnt_o  <= cnt_o + 1'b1;
      last_o <= tap_i;
      if (fresh_q) begin
        first_o <= tap_i;
        fresh_q <= 1'b0;
      end
    end
  end

  // R7: one extra bit keeps the sum exact before halving
  always_comb begin
    sum     = {1'b0, first_o} + {1'b0, last_o};
    final_o = (cnt_o == '0) ? DEF_V : sum[TAP_W:1];
  end

  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_o <= (TAP_W+1)'(2**TAP_W));
  a_r6_order: assert property (@(posedge clk) disable iff (rst)
    !fresh_q |-> first_o <= last_o);
  a_r8_empty_sentinel: assert property (@(posedge clk) disable iff (rst)
    (cnt_o == '0) |-> fresh_q);
endmodule

// File: rtl/tap_scan_seq.sv
module tap_scan_seq
  import tap_cal_pkg::*;
#(
  parameter int TAP_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             done_seen_i,
  output logic [TAP_W-1:0] cur_tap_o,
  output logic             go_o,
  output logic             clr_o,
  output logic             launch_o,
  output logic             sample_o,
  output logic             finish_o
);
  localparam logic [TAP_W-1:0] TAP_MAX = '1;

  scan_st_t st_q;

  always_comb begin
    clr_o    = (st_q == ST_IDLE) && start_i;
    launch_o = (st_q == ST_LAUNCH);
    sample_o = (st_q == ST_WAIT) && done_seen_i;
    finish_o = (st_q == ST_FINAL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      cur_tap_o <= '0;
      go_o      <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          cur_tap_o <= '0;
          st_q      <= ST_LAUNCH;
        end
        ST_LAUNCH: begin
          go_o <= 1'b1;
          st_q <= ST_WAIT;
        end
        ST_WAIT: if (done_seen_i) begin
          go_o <= 1'b0;
          if (cur_tap_o == TAP_MAX) begin
            st_q <= ST_FINAL;
          end else begin
            cur_tap_o <= cur_tap_o + 1'b1;
            st_q      <= ST_LAUNCH;
          end
        end
        ST_FINAL: st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  a_r3_drop_after_done: assert property (@(posedge clk) disable iff (rst)
    $fell(go_o) |-> $past(done_seen_i));
  a_r1_step_one: assert property (@(posedge clk) disable iff (rst)
    (sample_o && cur_tap_o != TAP_MAX) |=> cur_tap_o == TAP_W'($past(cur_tap_o) + 1'b1));
  a_r10_no_restart: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAIT && start_i && !done_seen_i) |=> cur_tap_o == $past(cur_tap_o));
endmodule

// File: rtl/tap_sweep_cal.sv
module tap_sweep_cal #(
  parameter int TAP_W   = 6,
  parameter int LANES   = 4,
  parameter int CNT_W   = 8,
  parameter int RUNS    = 8,
  parameter int DEF_TAP = 8,
  localparam int STAT_W = 2 * CNT_W + 1,
  localparam int CFG_W  = CNT_W + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cal_start_i,
  output logic                   cal_done_o,
  output logic [LANES*TAP_W-1:0] lane_tap_o,
  output logic                   bist_go_o,
  output logic [CFG_W-1:0]       bist_cfg_o,
  input  logic [STAT_W-1:0]      bist_stat_i,
  output logic [TAP_W:0]         pass_cnt_o,
  output logic [TAP_W-1:0]       first_tap_o,
  output logic [TAP_W-1:0]       last_tap_o
);
  logic             done_seen, tap_ok;
  logic [TAP_W-1:0] cur_tap, final_tap;
  logic             clr, launch, sample, finish;

  // R3: run count sits above bit 0 of the configuration word
  assign bist_cfg_o = {CNT_W'(RUNS), 1'b0};

  tap_status_judge #(.CNT_W(CNT_W), .RUNS(RUNS)) u_judge (
    .stat_i      (bist_stat_i),
    .done_seen_o (done_seen),
    .tap_ok_o    (tap_ok)
  );

  tap_scan_seq #(.TAP_W(TAP_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start_i     (cal_start_i),
    .done_seen_i (done_seen),
    .cur_tap_o   (cur_tap),
    .go_o        (bist_go_o),
    .clr_o       (clr),
    .launch_o    (launch),
    .sample_o    (sample),
    .finish_o    (finish)
  );

  tap_window_track #(.TAP_W(TAP_W), .DEF_TAP(DEF_TAP)) u_track (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (clr),
    .hit_i   (sample && tap_ok),
    .tap_i   (cur_tap),
    .first_o (first_tap_o),
    .last_o  (last_tap_o),
    .cnt_o   (pass_cnt_o),
    .final_o (final_tap)
  );

  // R2: one register per lane, all loaded from the same source
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [TAP_W-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (rst)         lane_q <= '0;
      else if (launch) lane_q <= cur_tap;
      else if (finish) lane_q <= final_tap;
    end
    assign lane_tap_o[g*TAP_W +: TAP_W] = lane_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cal_done_o <= 1'b0;
    else     cal_done_o <= finish;
  end

  a_r2_hold_during_test: assert property (@(posedge clk) disable iff (rst)
    (bist_go_o && $past(bist_go_o)) |-> $stable(lane_tap_o));
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    cal_done_o |=> !cal_done_o);
  a_r3_go_off_at_end: assert property (@(posedge clk) disable iff (rst)
    cal_done_o |-> !bist_go_o);
endmodule

// File: tb/tb_tap_sweep_cal.sv
module tb_tap_sweep_cal;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cal_start_i = 1'b0;
  logic        cal_done_o;
  logic [23:0] lane_tap_o;
  logic        bist_go_o;
  logic [8:0]  bist_cfg_o;
  logic [16:0] bist_stat_i = '0;
  logic [6:0]  pass_cnt_o;
  logic [5:0]  first_tap_o, last_tap_o;

  tap_sweep_cal dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  // pattern: passing window [p_lo,p_hi], two isolated passing taps, kind of failing status
  int p_lo, p_hi, p_x1, p_x2, p_kind;
  int tests, seq_err, lat_cnt, hold_err;
  logic go_prev = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit is_pass(input int t);
    return (t >= p_lo && t <= p_hi) || t == p_x1 || t == p_x2;
  endfunction

  function automatic logic [16:0] stat_for(input int t);
    int np, nf;
    if (is_pass(t)) begin np = 8; nf = 0; end
    else case (p_kind)
      1: begin np = 7; nf = 0; end
      2: begin np = 8; nf = 1; end
      3: begin np = 9; nf = 0; end
      default: begin np = 0; nf = 8; end
    endcase
    return {8'(nf), 8'(np), 1'b1};
  endfunction

  // test engine model and sweep monitor
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      if (bist_go_o && !go_prev) begin
        if (int'(lane_tap_o[5:0]) != tests) seq_err++;
        if (lane_tap_o != {4{lane_tap_o[5:0]}}) seq_err++;
        if (bist_cfg_o != 9'h010) seq_err++;
        tests++;
      end
      if (bist_go_o && go_prev && lane_tap_o != {4{lane_tap_o[5:0]}}) hold_err++;
      if (!bist_go_o) begin
        bist_stat_i <= '0;
        lat_cnt     <= 0;
      end else if (lat_cnt == LAT) begin
        bist_stat_i <= stat_for(int'(lane_tap_o[5:0]));
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
      go_prev <= bist_go_o;
    end
  end

  always @(negedge clk) begin
    if (cycles > 190000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic sweep(input int lo, input int hi, input int x1, input int x2,
                       input int kind, input bit poke);
    int ecnt, efirst, elast, efin, wait_n;
    p_lo = lo; p_hi = hi; p_x1 = x1; p_x2 = x2; p_kind = kind;
    ecnt = 0; efirst = 0; elast = 0;
    for (int t = 0; t < 64; t++) begin
      if (is_pass(t)) begin
        if (ecnt == 0) efirst = t;
        elast = t;
        ecnt++;
      end
    end
    efin = (ecnt == 0) ? 8 : ((efirst + elast) / 2);
    tests = 0; seq_err = 0; hold_err = 0;
    @(negedge clk); cal_start_i = 1'b1;
    @(negedge clk); cal_start_i = 1'b0;
    check("R5 count cleared at start", int'(pass_cnt_o), 0);
    wait_n = 0;
    while (!cal_done_o && wait_n < 2000) begin
      @(negedge clk);
      wait_n++;
      if (poke && tests == 10 && !cal_start_i) cal_start_i = 1'b1;
      else cal_start_i = 1'b0;
    end
    cal_start_i = 1'b0;
    check("R9 done seen", int'(cal_done_o), 1);
    check(poke ? "R10 start ignored, tests" : "R1 tests per sweep", tests, 64);
    check("R1 R3 tap order and config", seq_err, 0);
    check("R2 lanes equal and held", hold_err, 0);
    check("R5 pass count", int'(pass_cnt_o), ecnt);
    check("R6 first tap", int'(first_tap_o), efirst);
    check("R6 last tap", int'(last_tap_o), elast);
    check(ecnt == 0 ? "R8 fallback tap" : "R7 centred tap", int'(lane_tap_o[5:0]), efin);
    check("R2 final on all lanes", int'(lane_tap_o), int'({4{6'(efin)}}));
    @(negedge clk);
    check("R9 done one cycle", int'(cal_done_o), 0);
    check("R9 final held", int'(lane_tap_o[5:0]), efin);
    check("R3 go low after sweep", int'(bist_go_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 reset done low", int'(cal_done_o), 0);
    check("R3 reset go low", int'(bist_go_o), 0);
    check("R2 reset lanes", int'(lane_tap_o), 0);
    check("R5 reset count", int'(pass_cnt_o), 0);
    check("R3 config word", int'(bist_cfg_o), 16);
    // R8: nothing passes, each failing status kind
    for (int k = 0; k < 4; k++) sweep(-1, -2, -1, -1, k, 1'b0);
    // R6 R7: exhaustive single passing tap
    for (int t = 0; t < 64; t++) sweep(t, t, -1, -1, t % 4, 1'b0);
    sweep(0, 63, -1, -1, 0, 1'b0);   // all pass, centre 31
    sweep(10, 20, -1, -1, 1, 1'b0);  // window, R4 near miss 7 passes
    sweep(62, 63, -1, -1, 3, 1'b0);  // R7 7-bit sum
    sweep(-1, -2, 5, 60, 2, 1'b0);   // R6 split region
    sweep(30, 33, 2, 50, 0, 1'b0);   // mixed
    sweep(12, 40, -1, -1, 0, 1'b1);  // R10 start during sweep
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule